// File: doc/BRIEF.md
# Line-Card PCM Serial Port with Signaling Insertion

This block sits on the switch side of a two-wire subscriber link. Toward the backplane it looks like a codec serial port. A receive enable and a data pin deliver one 8-bit voice word per frame. A transmit enable and a tri-stated data pin return the word that arrived from the far end. Both directions run on one shared data clock. Toward the line it hands a 10-bit parallel word to the modulator with a one-cycle strobe at every frame sync. It takes back a demodulated voice word, two signaling bits and a good/bad flag with a done strobe.

The data clock and the frame sync are plain levels sampled in one system clock domain. Their edges act as enables. An optional mode carries the second signaling channel inside the voice word's LSB, so data can travel through the switch's voice path. A bus-enable input lets several ports share signaling wiring. While it is low, the port holds its control inputs at their last values and turns its status outputs off.

Top module: `pcm_port_master`

## Requirements
- R1: After a rising edge of `rxen_i`, `rxd_i` is sampled on the next eight falling edges of `dclk_i`, MSB first. The assembled byte becomes the port's current voice word after the eighth sample.
- R2: On each rising edge of `fsync_i`, `md_strobe_o` pulses for exactly one cycle. `md_word_o` then holds the voice word in bits [9:2], signaling bit A in bit 1 and signaling bit B in bit 0. Bits A and B are sampled at that edge.
- R3: `txd_oe_o` is low whenever `txen_i` is low. The MSB of the transmit register appears on the `dclk_i` rising edge that coincides with the `txen_i` rise. Each of the next seven `dclk_i` rising edges presents the next bit.
- R4: A frame sync that arrives while no transmit window is open copies the latest demodulated word into the transmit register at that edge.
- R5: A frame sync that arrives inside an open window (`txen_i` high, fewer than nine data clock rises seen) leaves the current window untouched. The copy happens at the ninth `dclk_i` rise after `txen_i` rose.
- R6: `sig_a_o`, `sig_b_o` and `valid_o` change only on a frame sync. The signaling outputs take the bits of the last burst; `dm_sig_i[1]` is A and `dm_sig_i[0]` is B. `valid_o` is 1 only if a burst with `dm_ok_i` high was reported since the previous sync.
- R7: With `lsb_sig_i` high, three things change. The transmit word's LSB becomes received bit B. Bit B sent to the line is the received voice word's LSB instead of `sig_b_i`. Bit 2 of `md_word_o` is forced to 0.
- R8: While `bus_en_i` is low, `stat_oe_o` is low. The power, loopback, signaling and LSB-mode inputs act at the values they had on the last cycle `bus_en_i` was high.
- R9: After reset, the following outputs are low: `txd_oe_o`, `md_strobe_o`, `valid_o`, `sig_a_o` and `sig_b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| dclk_i | input | 1 | backplane data clock level |
| fsync_i | input | 1 | frame sync level |
| rxen_i | input | 1 | receive window enable |
| rxd_i | input | 1 | serial voice data in |
| txen_i | input | 1 | transmit window enable |
| txd_o | output | 1 | serial voice data out |
| txd_oe_o | output | 1 | drive enable for txd_o |
| sig_a_i | input | 1 | signaling bit A to line |
| sig_b_i | input | 1 | signaling bit B to line |
| lsb_sig_i | input | 1 | carry bit B in voice LSB |
| pwr_up_i | input | 1 | power-up request |
| loop_n_i | input | 1 | loopback request, active low |
| bus_en_i | input | 1 | bus enable; low freezes controls |
| pwr_up_o | output | 1 | effective power-up control |
| loop_n_o | output | 1 | effective loopback control |
| sig_a_o | output | 1 | received signaling bit A |
| sig_b_o | output | 1 | received signaling bit B |
| valid_o | output | 1 | last frame held a good burst |
| stat_oe_o | output | 1 | drive enable for status outputs |
| md_word_o | output | 10 | word for the modulator |
| md_strobe_o | output | 1 | md_word_o is new |
| dm_done_i | input | 1 | demodulation complete strobe |
| dm_voice_i | input | 8 | demodulated voice word |
| dm_sig_i | input | 2 | demodulated signaling {A,B} |
| dm_ok_i | input | 1 | burst had no errors |

## Verification
The checker watches five behaviours on every cycle. The modulator strobe lasts one cycle and follows a sync edge. The status outputs move only together with that strobe. The forced-zero LSB appears in LSB mode. The controls stay frozen while the bus is released. The transmit driver is off outside a window. Bit order, the choice between immediate and deferred transfer, the substitution of bit B in both directions and the clearing of the valid flag all depend on data. Only the bench's scripted frames show them, comparing each serialized byte and modulator word against values it works out itself.

// File: rtl/pcm_port_pkg.sv
// Shared sizes and the control bundle for the line-card PCM port.
package pcm_port_pkg;
    localparam int WORD_W = 8;  // voice word width
    localparam int SIG_W  = 2;  // signaling bits per frame

    // Control inputs frozen together while the bus is released.
    typedef struct packed {
        logic pwr_up;
        logic loop_n;
        logic sig_a;
        logic sig_b;
        logic lsb_sig;
    } ctl_t;
endpackage

// File: rtl/pcm_edge_det.sv
// Holds the previous sampled level of N slow strobes so the parent can form
// edge enables. Assumes inputs are already synchronous to clk.
module pcm_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] prev
);
    // Register last-cycle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= d;
    end
endmodule

// File: rtl/pcm_rx_deser.sv
// Collects one voice word from the serial input: eight samples on data clock
// falling edges after the receive enable rises, MSB first.
module pcm_rx_deser #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxen_rise,
    input  logic              dclk_fall,
    input  logic              rxd,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [CNT_W-1:0]  left;
    logic [WORD_W-1:0] sh;

    // Arm on enable, shift on falling edges, publish after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
            sh   <= '0;
            word <= '0;
        end else if (rxen_rise) begin
            left <= CNT_W'(WORD_W);
        end else if (dclk_fall && left != '0) begin
            sh   <= {sh[WORD_W-2:0], rxd};
            left <= left - 1'b1;
            if (left == CNT_W'(1)) word <= {sh[WORD_W-2:0], rxd};
        end
    end
endmodule

// File: rtl/pcm_tx_ser.sv
// Transmit register and serializer. The register is indexed by a rise counter
// so the output follows the register live. A load request inside an open
// window is held until the ninth data clock rise of that window.
module pcm_tx_ser #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txen,
    input  logic              txen_rise,
    input  logic              dclk_rise,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              txd,
    output logic              txd_oe
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  n;
    logic [WORD_W-1:0] tx_reg, pend;
    logic              defer, in_win;

    assign in_win = txen && (n != IDLE);

    // Count rises in the window and apply immediate or deferred loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n      <= IDLE;
            tx_reg <= '0;
            pend   <= '0;
            defer  <= 1'b0;
        end else begin
            if (txen_rise)                    n <= '0;
            else if (dclk_rise && n != IDLE)  n <= n + 1'b1;

            if (load && in_win) begin
                pend  <= word;
                defer <= 1'b1;
            end else if (load) begin
                tx_reg <= word;
            end else if (defer && dclk_rise && !txen_rise && n == LAST) begin
                tx_reg <= pend;
                defer  <= 1'b0;
            end
        end
    end

    // Pick the bit for the current rise count, MSB first.
    always_comb begin
        txd = 1'b0;
        for (int i = 0; i < WORD_W; i++)
            if (n == CNT_W'(i)) txd = tx_reg[WORD_W-1-i];
    end

    assign txd_oe = txen && (n != IDLE);
endmodule

// File: rtl/pcm_frame_ctl.sv
// Frame-sync work: bus-enable latch of controls, modulator word assembly,
// demodulation buffer and status outputs, and the transmit word with
// optional signaling substitution in its LSB.
module pcm_frame_ctl
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int SIG_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fsync_rise,
    input  logic                    bus_en,
    input  ctl_t                    ctl_pins,
    input  logic [WORD_W-1:0]       rx_word,
    input  logic                    dm_done,
    input  logic [WORD_W-1:0]       dm_voice,
    input  logic [SIG_W-1:0]        dm_sig,
    input  logic                    dm_ok,
    output ctl_t                    ctl_eff,
    output logic [WORD_W+SIG_W-1:0] md_word,
    output logic                    md_strobe,
    output logic [SIG_W-1:0]        sig_out,
    output logic                    valid,
    output logic                    tx_load,
    output logic [WORD_W-1:0]       tx_word
);
    ctl_t              ctl_l;
    logic [WORD_W-1:0] dbuf_voice;
    logic [SIG_W-1:0]  dbuf_sig;
    logic              dbuf_ok;
    logic              line_b;
    logic [WORD_W-1:0] line_voice;

    // Track control pins while the bus is ours; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_l <= '0;
        else if (bus_en) ctl_l <= ctl_pins;
    end

    assign ctl_eff = bus_en ? ctl_pins : ctl_l;

    // Line-bound bit B and voice LSB under LSB-carry mode.
    assign line_b     = ctl_eff.lsb_sig ? rx_word[0] : ctl_eff.sig_b;
    assign line_voice = {rx_word[WORD_W-1:1], rx_word[0] & ~ctl_eff.lsb_sig};

    // Backplane-bound word with bit B in its LSB under LSB-carry mode.
    assign tx_word = {dbuf_voice[WORD_W-1:1],
                      ctl_eff.lsb_sig ? dbuf_sig[0] : dbuf_voice[0]};
    assign tx_load = fsync_rise;

    // Catch demodulated bursts; the good flag is consumed by each sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbuf_voice <= '0;
            dbuf_sig   <= '0;
            dbuf_ok    <= 1'b0;
        end else if (dm_done) begin
            dbuf_voice <= dm_voice;
            dbuf_sig   <= dm_sig;
            dbuf_ok    <= dm_ok;
        end else if (fsync_rise) begin
            dbuf_ok    <= 1'b0;
        end
    end

    // At sync: publish modulator word and update status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_word   <= '0;
            md_strobe <= 1'b0;
            sig_out   <= '0;
            valid     <= 1'b0;
        end else begin
            md_strobe <= fsync_rise;
            if (fsync_rise) begin
                md_word <= {line_voice, ctl_eff.sig_a, line_b};
                sig_out <= dbuf_sig;
                valid   <= dbuf_ok;
            end
        end
    end
endmodule

// File: rtl/pcm_port_master.sv
// Top of the line-card PCM port. Derives edge enables from the sampled data
// clock, sync and enables, and wires receive, transmit and frame logic.
// Assumes all inputs are synchronous to clk and the data clock is slower
// than clk/2.
module pcm_port_master
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = pcm_port_pkg::WORD_W,
    parameter int SIG_W  = pcm_port_pkg::SIG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dclk_i,
    input  logic                    fsync_i,
    input  logic                    rxen_i,
    input  logic                    rxd_i,
    input  logic                    txen_i,
    output logic                    txd_o,
    output logic                    txd_oe_o,
    input  logic                    sig_a_i,
    input  logic                    sig_b_i,
    input  logic                    lsb_sig_i,
    input  logic                    pwr_up_i,
    input  logic                    loop_n_i,
    input  logic                    bus_en_i,
    output logic                    pwr_up_o,
    output logic                    loop_n_o,
    output logic                    sig_a_o,
    output logic                    sig_b_o,
    output logic                    valid_o,
    output logic                    stat_oe_o,
    output logic [WORD_W+SIG_W-1:0] md_word_o,
    output logic                    md_strobe_o,
    input  logic                    dm_done_i,
    input  logic [WORD_W-1:0]       dm_voice_i,
    input  logic [SIG_W-1:0]        dm_sig_i,
    input  logic                    dm_ok_i
);
    logic [3:0]        lvl, prev, rise;
    logic              dclk_fall;
    logic [WORD_W-1:0] rx_word, tx_word;
    logic              tx_load;
    logic [SIG_W-1:0]  sig_out;
    ctl_t              ctl_pins, ctl_eff;

    assign lvl       = {txen_i, rxen_i, fsync_i, dclk_i};
    assign rise      = lvl & ~prev;
    assign dclk_fall = ~dclk_i & prev[0];
    assign ctl_pins  = '{pwr_up: pwr_up_i, loop_n: loop_n_i, sig_a: sig_a_i,
                         sig_b: sig_b_i, lsb_sig: lsb_sig_i};

    pcm_edge_det #(.N(4)) u_edge (
        .clk(clk), .rst_n(rst_n), .d(lvl), .prev(prev)
    );

    pcm_rx_deser #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxen_rise(rise[2]), .dclk_fall(dclk_fall),
        .rxd(rxd_i), .word(rx_word)
    );

    pcm_frame_ctl #(.WORD_W(WORD_W), .SIG_W(SIG_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .fsync_rise(rise[1]), .bus_en(bus_en_i),
        .ctl_pins(ctl_pins), .rx_word(rx_word), .dm_done(dm_done_i),
        .dm_voice(dm_voice_i), .dm_sig(dm_sig_i), .dm_ok(dm_ok_i),
        .ctl_eff(ctl_eff), .md_word(md_word_o), .md_strobe(md_strobe_o),
        .sig_out(sig_out), .valid(valid_o), .tx_load(tx_load),
        .tx_word(tx_word)
    );

    pcm_tx_ser #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .txen(txen_i), .txen_rise(rise[3]),
        .dclk_rise(rise[0]), .load(tx_load), .word(tx_word),
        .txd(txd_o), .txd_oe(txd_oe_o)
    );

    assign sig_a_o   = sig_out[1];
    assign sig_b_o   = sig_out[0];
    assign stat_oe_o = bus_en_i;
    assign pwr_up_o  = ctl_eff.pwr_up;
    assign loop_n_o  = ctl_eff.loop_n;
endmodule

// File: rtl/pcm_port_master_chk.sv
// Property checker for pcm_port_master, attached by bind below.
module pcm_port_master_chk #(
    parameter int WORD_W = 8,
    parameter int SIG_W  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fsync_i,
    input logic                    txen_i,
    input logic                    txd_oe_o,
    input logic                    lsb_sig_i,
    input logic                    bus_en_i,
    input logic                    pwr_up_o,
    input logic                    loop_n_o,
    input logic                    sig_a_o,
    input logic                    sig_b_o,
    input logic                    valid_o,
    input logic                    stat_oe_o,
    input logic [WORD_W+SIG_W-1:0] md_word_o,
    input logic                    md_strobe_o
);
    // R2: strobe lasts a single cycle
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        md_strobe_o |=> !md_strobe_o);

    // R2: strobe follows a sync rising edge
    a_r2_strobe_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        md_strobe_o |-> ($past(fsync_i) && !$past(fsync_i, 2)));

    // R3: driver off outside a window, on once a window opens
    a_r3_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !txen_i |-> !txd_oe_o);
    a_r3_window_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txen_i) |=> (txd_oe_o || !txen_i));

    // R6: status moves only with the sync strobe
    a_r6_status_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ((sig_a_o != $past(sig_a_o)) || (sig_b_o != $past(sig_b_o)) ||
         (valid_o != $past(valid_o))) |-> md_strobe_o);

    // R7: voice LSB toward the line is zero in LSB-carry mode
    a_r7_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (md_strobe_o && $past(bus_en_i) && $past(lsb_sig_i)) |-> !md_word_o[SIG_W]);

    // R8: released bus turns status off and freezes controls
    a_r8_status_off: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en_i |-> !stat_oe_o);
    a_r8_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en_i && !$past(bus_en_i)) |-> ($stable(pwr_up_o) && $stable(loop_n_o)));
endmodule

bind pcm_port_master pcm_port_master_chk #(.WORD_W(WORD_W), .SIG_W(SIG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .txen_i(txen_i),
    .txd_oe_o(txd_oe_o), .lsb_sig_i(lsb_sig_i), .bus_en_i(bus_en_i),
    .pwr_up_o(pwr_up_o), .loop_n_o(loop_n_o), .sig_a_o(sig_a_o),
    .sig_b_o(sig_b_o), .valid_o(valid_o), .stat_oe_o(stat_oe_o),
    .md_word_o(md_word_o), .md_strobe_o(md_strobe_o)
);

// File: tb/sim_pcm_port_master.sv
// Scoreboard bench: tasks queue expected modulator words and transmit bytes,
// a monitor pops modulator words as strobes appear.
module sim_pcm_port_master;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dclk = 0, fsync = 0, rxen = 0, rxd = 0, txen = 0;
    logic sa = 0, sb = 0, lsb = 0, pwr = 1, lpn = 1, ben = 1;
    logic dm_done = 0, dm_ok = 0;
    logic [7:0] dm_voice = '0;
    logic [1:0] dm_sig = '0;
    logic txd, txd_oe, pwr_o, lpn_o, sa_o, sb_o, vld, soe, mds;
    logic [9:0] mdw;

    int checks = 0, fails = 0;
    logic [9:0] md_q[$];
    logic [7:0] got;

    always #(CLK_P/2) clk = ~clk;

    pcm_port_master u0 (
        .clk(clk), .rst_n(rst_n), .dclk_i(dclk), .fsync_i(fsync), .rxen_i(rxen),
        .rxd_i(rxd), .txen_i(txen), .txd_o(txd), .txd_oe_o(txd_oe),
        .sig_a_i(sa), .sig_b_i(sb), .lsb_sig_i(lsb), .pwr_up_i(pwr),
        .loop_n_i(lpn), .bus_en_i(ben), .pwr_up_o(pwr_o), .loop_n_o(lpn_o),
        .sig_a_o(sa_o), .sig_b_o(sb_o), .valid_o(vld), .stat_oe_o(soe),
        .md_word_o(mdw), .md_strobe_o(mds), .dm_done_i(dm_done),
        .dm_voice_i(dm_voice), .dm_sig_i(dm_sig), .dm_ok_i(dm_ok)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: serial receive, MSB first on falling edges
    task automatic rx_byte(input logic [7:0] b);
        rxen = 1; dclk = 1; tick(4);
        for (int i = 0; i < 8; i++) begin
            dclk = 0; rxd = b[7-i]; tick(4);
            dclk = 1; tick(4);
        end
        dclk = 0; rxen = 0; tick(4);
    endtask

    task automatic sync_pulse();
        fsync = 1; tick(2); fsync = 0; tick(2);
    endtask

    task automatic burst(input logic [7:0] v, input logic [1:0] s, input logic ok);
        dm_voice = v; dm_sig = s; dm_ok = ok; dm_done = 1; tick(1);
        dm_done = 0; tick(1);
    endtask

    // R3: read one window; optional sync in the middle of it
    task automatic tx_read(input logic mid, output logic [7:0] b);
        txen = 1; dclk = 1; tick(2);
        b[7] = txd;
        chk("R3 oe in window", 16'(txd_oe), 16'd1);
        tick(2);
        for (int k = 1; k < 8; k++) begin
            dclk = 0;
            if (mid && k == 4) fsync = 1;
            tick(2); fsync = 0; tick(2);
            dclk = 1; tick(2); b[7-k] = txd; tick(2);
        end
        dclk = 0; tick(4); dclk = 1; tick(4);
        txen = 0; dclk = 0; tick(4);
        chk("R3 oe after window", 16'(txd_oe), 16'd0);
    endtask

    // Scoreboard monitor for modulator words (R2)
    always @(negedge clk) begin
        if (rst_n && mds) begin
            if (md_q.size() == 0) chk("R2 unexpected strobe", 16'(mdw), 16'hFFFF);
            else chk("R2 md word", 16'(mdw), 16'(md_q.pop_front()));
        end
    end

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(5); rst_n = 1; tick(2);
        // R9 reset state
        chk("R9 oe", 16'(txd_oe), 16'd0);
        chk("R9 strobe", 16'(mds), 16'd0);
        chk("R9 status", 16'({vld, sa_o, sb_o}), 16'd0);

        // R1 R2: plain frame, no burst so valid stays low
        sa = 1; sb = 0; rx_byte(8'hA5);
        md_q.push_back({8'hA5, 1'b1, 1'b0}); sync_pulse();
        chk("R6 no burst valid", 16'(vld), 16'd0);

        // R4 R6: burst then sync outside window
        burst(8'h96, 2'b01, 1'b1);
        sa = 0; sb = 1; rx_byte(8'h3C);
        md_q.push_back({8'h3C, 1'b0, 1'b1}); sync_pulse();
        chk("R6 sig", 16'({sa_o, sb_o}), 16'b01);
        chk("R6 valid", 16'(vld), 16'd1);
        tx_read(1'b0, got);
        chk("R4 R3 tx byte", 16'(got), 16'h96);

        // R5: sync inside window defers the copy
        burst(8'h5A, 2'b10, 1'b1);
        md_q.push_back({8'h3C, 1'b0, 1'b1});
        tx_read(1'b1, got);
        chk("R5 window untouched", 16'(got), 16'h96);
        chk("R6 sig after mid sync", 16'({sa_o, sb_o, vld}), 16'b101);
        tx_read(1'b0, got);
        chk("R5 deferred word", 16'(got), 16'h5A);

        // R6: frame without burst clears valid
        md_q.push_back({8'h3C, 1'b0, 1'b1}); sync_pulse();
        chk("R6 valid cleared", 16'(vld), 16'd0);

        // R7: LSB-carry mode both directions
        lsb = 1; sa = 1; sb = 0; rx_byte(8'h3B);
        burst(8'hF0, 2'b11, 1'b1);
        md_q.push_back({8'h3A, 1'b1, 1'b1}); sync_pulse();
        tx_read(1'b0, got);
        chk("R7 tx lsb from bit B", 16'(got), 16'hF1);

        // R6: bad burst leaves valid low
        burst(8'h11, 2'b00, 1'b0);
        md_q.push_back({8'h3A, 1'b1, 1'b1}); sync_pulse();
        chk("R6 bad burst", 16'({vld, sa_o, sb_o}), 16'b000);

        // R8: bus released, controls frozen
        ben = 0; tick(2);
        chk("R8 stat off", 16'(soe), 16'd0);
        sa = 0; lsb = 0; pwr = 0; lpn = 0; tick(2);
        chk("R8 frozen ctl", 16'({pwr_o, lpn_o}), 16'b11);
        md_q.push_back({8'h3A, 1'b1, 1'b1}); sync_pulse();
        ben = 1; tick(2);
        chk("R8 released ctl", 16'({pwr_o, lpn_o, soe}), 16'b001);

        tick(4);
        chk("R2 queue drained", 16'(md_q.size()), 16'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule